// File: doc/BRIEF.md
# Frame-Cadence Divider with External Realignment

This block turns a line-rate horizontal sync and a line number into a stream of frame ticks. One tick is made per frame, at the rising edge of horizontal sync while the line number reads 1. Two counters run on those ticks. The first is the frame-ID divider. Its period is 5 frames in the 30-frame-per-second mode and 10 frames in the 60-frame-per-second mode. Its output stays high for the whole frame in which its count is zero. The second is the audio-sequence divider. It has a programmable period of 1 to 10 frames and gives a one-clock pulse each time it returns to zero.

An external frame-ID input realigns the dividers. It is looked at only on a frame tick. When it is high at a tick, the frame-ID divider is forced to zero on that same tick, so the output pulse begins in that frame. The audio divider is forced to zero on that tick as well, unless a mask input breaks this coupling. When the reference carries no frame-ID signal, the input is tied low and both dividers free-run. Horizontal sync comes in with its polarity already normalised, so its leading edge is always a rising edge.

Top module: `frame_cadence_div`

## Requirements
- R1: While `rst` is high at a clock edge, both counters and both outputs are cleared. After release, the first frame tick moves the frame-ID count from 0 to 1.
- R2: A frame tick is made only when `hsync` goes from 0 to 1 while `line_num` equals 1. A rising edge on any other line makes no tick. Holding `hsync` high across several clocks makes a single tick.
- R3: With `rate_sel`=0 the frame-ID divider has period 5. With `rate_sel`=1 it has period 10.
- R4: `fid_out` changes only on the clock after a frame tick. It is then high exactly when the new frame-ID count is 0, and it holds that value until the next tick.
- R5: A frame tick with `fid_in`=1 forces the frame-ID count to 0, so `fid_out` is high for that frame.
- R6: With `aud_clr_mask`=0, a frame tick with `fid_in`=1 also forces the audio count to 0 and pulses `afs_out`. With `aud_clr_mask`=1, the audio divider ignores `fid_in`.
- R7: The audio divider counts frame ticks modulo `aud_period`. It drives `afs_out` high for exactly one clock after each tick on which its count becomes 0. A period of 0 acts as 1, and a period above 10 acts as 10.
- R8: If a count is at or above its current period minus one, for example after a switch from period 10 to period 5, it wraps to 0 on the next tick.
- R9: `fid_in` has no effect when there is no frame tick, including on a rising edge of `hsync` on a line other than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | input | 1 | Horizontal sync with normalised polarity; the leading edge is a rising edge |
| line_num | input | LINE_W | Current line number from the upstream line counter |
| fid_in | input | 1 | External frame-ID realignment request |
| rate_sel | input | 1 | 0: period of 5 frames, 1: period of 10 frames |
| aud_clr_mask | input | 1 | 1 stops `fid_in` from clearing the audio divider |
| aud_period | input | 4 | Audio-sequence period in frames (1 to 10) |
| fid_out | output | 1 | High for the whole frame in which the frame-ID count is 0 |
| afs_out | output | 1 | One-clock pulse when the audio count wraps to 0 |

## Verification
The case that is hardest to reach is a count left above the new period after a mode switch. The stimulus first runs the 10-frame mode until the count is 7, then changes `rate_sel` and checks that the very next tick gives a zero-count frame. The other hard cases are frames where a tick must not happen: an edge on the wrong line while `fid_in` is high, and `hsync` held high. For these the bench counts the ticks until the next `fid_out`, so that any tick the design wrongly took, or any realignment it wrongly applied, changes the count it measures.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    localparam int MAX_PERIOD = 10;
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);
    localparam int SLOW_N     = 5;
    localparam int FAST_N     = 10;
    localparam int LINE_W_DEF = 11;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        RATE_30 = 1'b0,
        RATE_60 = 1'b1
    } rate_e;

    typedef struct packed {
        logic tick;
        logic fid_clr;
        logic aud_clr;
    } frame_evt_t;

    function automatic cnt_t clamp_period(input cnt_t p);
        if (p == '0)
            return cnt_t'(1);
        else if (p > cnt_t'(MAX_PERIOD))
            return cnt_t'(MAX_PERIOD);
        else
            return p;
    endfunction

    function automatic cnt_t cadence_of(input rate_e r);
        return (r == RATE_60) ? cnt_t'(FAST_N) : cnt_t'(SLOW_N);
    endfunction
endpackage

// File: rtl/fcd_line1_tick.sv
module fcd_line1_tick #(
    parameter int LINE_W     = 11,
    parameter int FIRST_LINE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic [LINE_W-1:0] line_num,
    output logic              tick
);
    logic hs_q;

    always_ff @(posedge clk) begin
        if (rst)
            hs_q <= 1'b0;
        else
            hs_q <= hsync;
    end

    always_comb begin
        tick = hsync && !hs_q && (line_num == LINE_W'(FIRST_LINE));
    end
endmodule

// File: rtl/fcd_frame_div.sv
module fcd_frame_div
    import fcd_pkg::*;
#(
    parameter bit PULSE_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clr,
    input  cnt_t period,
    output cnt_t cnt,
    output logic ev
);
    cnt_t nxt;

    always_comb begin
        if (clr)
            nxt = '0;
        else if (cnt >= period - cnt_t'(1))
            nxt = '0;
        else
            nxt = cnt + cnt_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= nxt;
    end

    generate
        if (PULSE_OUT) begin : g_pulse
            always_ff @(posedge clk) begin
                if (rst)
                    ev <= 1'b0;
                else
                    ev <= tick && (nxt == '0);
            end
        end else begin : g_level
            always_ff @(posedge clk) begin
                if (rst)
                    ev <= 1'b0;
                else if (tick)
                    ev <= (nxt == '0);
            end
        end
    endgenerate
endmodule

// File: rtl/frame_cadence_div.sv
module frame_cadence_div
    import fcd_pkg::*;
#(
    parameter int LINE_W = LINE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic [LINE_W-1:0] line_num,
    input  logic              fid_in,
    input  logic              rate_sel,
    input  logic              aud_clr_mask,
    input  logic [3:0]        aud_period,
    output logic              fid_out,
    output logic              afs_out
);
    frame_evt_t evt;
    logic       tick;
    cnt_t       fid_cnt;
    cnt_t       aud_cnt;
    cnt_t       fid_per;
    cnt_t       aud_per;

    fcd_line1_tick #(.LINE_W(LINE_W), .FIRST_LINE(1)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .hsync    (hsync),
        .line_num (line_num),
        .tick     (tick)
    );

    always_comb begin
        evt.tick    = tick;
        evt.fid_clr = fid_in;
        evt.aud_clr = fid_in && !aud_clr_mask;
        fid_per     = cadence_of(rate_e'(rate_sel));
        aud_per     = clamp_period(cnt_t'(aud_period));
    end

    fcd_frame_div #(.PULSE_OUT(1'b0)) u_fid_div (
        .clk    (clk),
        .rst    (rst),
        .tick   (evt.tick),
        .clr    (evt.fid_clr),
        .period (fid_per),
        .cnt    (fid_cnt),
        .ev     (fid_out)
    );

    fcd_frame_div #(.PULSE_OUT(1'b1)) u_aud_div (
        .clk    (clk),
        .rst    (rst),
        .tick   (evt.tick),
        .clr    (evt.aud_clr),
        .period (aud_per),
        .cnt    (aud_cnt),
        .ev     (afs_out)
    );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic tick,
    input logic fid_in,
    input logic aud_clr_mask,
    input cnt_t fid_cnt,
    input cnt_t aud_cnt,
    input logic fid_out,
    input logic afs_out
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!fid_out && !afs_out && fid_cnt == '0 && aud_cnt == '0));

    a_r4_fid_holds: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(fid_out));

    a_r5_fid_realign: assert property (@(posedge clk) disable iff (rst)
        (tick && fid_in) |=> (fid_out && fid_cnt == '0));

    a_r6_aud_coupled: assert property (@(posedge clk) disable iff (rst)
        (tick && fid_in && !aud_clr_mask) |=> (afs_out && aud_cnt == '0));

    a_r7_afs_after_tick: assert property (@(posedge clk) disable iff (rst)
        afs_out |-> $past(tick));

    a_r7_afs_one_clock: assert property (@(posedge clk) disable iff (rst)
        afs_out |=> !afs_out);

    a_r8_count_in_range: assert property (@(posedge clk) disable iff (rst)
        (fid_cnt < cnt_t'(MAX_PERIOD)) && (aud_cnt < cnt_t'(MAX_PERIOD)));
endmodule

bind frame_cadence_div fcd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .fid_in       (fid_in),
    .aud_clr_mask (aud_clr_mask),
    .fid_cnt      (fid_cnt),
    .aud_cnt      (aud_cnt),
    .fid_out      (fid_out),
    .afs_out      (afs_out)
);

// File: tb/sim_frame_cadence_div.sv
`timescale 1ns/1ps
module sim_frame_cadence_div;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst;
    logic          hsync;
    logic [LW-1:0] line_num;
    logic          fid_in;
    logic          rate_sel;
    logic          aud_clr_mask;
    logic [3:0]    aud_period;
    logic          fid_out;
    logic          afs_out;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    frame_cadence_div #(.LINE_W(LW)) u0 (
        .clk(clk), .rst(rst), .hsync(hsync), .line_num(line_num),
        .fid_in(fid_in), .rate_sel(rate_sel), .aud_clr_mask(aud_clr_mask),
        .aud_period(aud_period), .fid_out(fid_out), .afs_out(afs_out)
    );

    // [8] rate, [7] mask, [6:3] period, [2] fid_in, [1] exp fid_out, [0] exp afs_out
    localparam logic [8:0] VEC [12] = '{
        9'b0_0_0011_0_0_0,
        9'b0_0_0011_0_0_0,
        9'b0_0_0011_0_0_1,
        9'b0_0_0011_0_0_0,
        9'b0_0_0011_0_1_0,
        9'b0_0_0011_0_0_1,
        9'b0_0_0011_1_1_1,
        9'b0_0_0011_0_0_0,
        9'b0_1_0011_1_1_0,
        9'b0_1_0011_0_0_1,
        9'b1_0_0001_0_0_1,
        9'b1_0_0001_0_0_1
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_edge(input int line, input bit fid);
        @(negedge clk);
        line_num = LW'(line);
        fid_in   = fid;
        hsync    = 1'b1;
        @(negedge clk);
        hsync  = 1'b0;
        fid_in = 1'b0;
    endtask

    task automatic ticks_until(input bit want_afs, input int lim, output int n);
        n = 0;
        for (int k = 1; k <= lim; k++) begin
            do_edge(1, 1'b0);
            if ((want_afs ? afs_out : fid_out) == 1'b1) begin
                n = k;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; hsync = 1'b0; line_num = '0; fid_in = 1'b0;
        rate_sel = 1'b0; aud_clr_mask = 1'b0; aud_period = 4'd3;
        repeat (3) @(negedge clk);
        check(fid_out == 1'b0 && afs_out == 1'b0, "R1 reset outputs", {fid_out, afs_out}, 0);
        rst = 1'b0;

        // table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < 12; i++) begin
            rate_sel     = VEC[i][8];
            aud_clr_mask = VEC[i][7];
            aud_period   = VEC[i][6:3];
            do_edge(1, VEC[i][2]);
            check(fid_out == VEC[i][1], $sformatf("R3/R4/R5 row %0d fid_out", i), fid_out, VEC[i][1]);
            check(afs_out == VEC[i][0], $sformatf("R6/R7 row %0d afs_out", i), afs_out, VEC[i][0]);
        end

        // R2 and R9: rising edge on line 2 with fid_in high is ignored (count was 3, period 10)
        do_edge(2, 1'b1);
        check(afs_out == 1'b0, "R2 no tick off line 1", afs_out, 0);
        ticks_until(1'b0, 12, n);
        check(n == 7, "R9 fid_in ignored without tick", n, 7);

        // R2: hsync held high on line 1 gives one tick only (count 0 -> 1)
        @(negedge clk);
        line_num = LW'(1); hsync = 1'b1;
        repeat (4) @(negedge clk);
        hsync = 1'b0;
        ticks_until(1'b0, 12, n);
        check(n == 9, "R2 held hsync single tick", n, 9);

        // R8: count 7 in period 10, switch to period 5, next tick wraps
        repeat (7) do_edge(1, 1'b0);
        check(fid_out == 1'b0, "R8 count 7 not zero", fid_out, 0);
        rate_sel = 1'b0;
        do_edge(1, 1'b0);
        check(fid_out == 1'b1, "R8 wrap after mode switch", fid_out, 1);

        // R7: period 0 acts as 1
        aud_period = 4'd0;
        do_edge(1, 1'b0);
        check(afs_out == 1'b1, "R7 period 0 first tick", afs_out, 1);
        do_edge(1, 1'b0);
        check(afs_out == 1'b1, "R7 period 0 second tick", afs_out, 1);

        // R6 then R7: period 15 acts as 10
        aud_period = 4'd15; aud_clr_mask = 1'b0;
        do_edge(1, 1'b1);
        check(afs_out == 1'b1, "R6 coupled realign pulse", afs_out, 1);
        ticks_until(1'b1, 16, n);
        check(n == 10, "R7 period 15 clamps to 10", n, 10);

        // R1: reset mid-run, then period 5 from count 0
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(fid_out == 1'b0 && afs_out == 1'b0, "R1 mid-run reset", {fid_out, afs_out}, 0);
        rst = 1'b0;
        ticks_until(1'b0, 12, n);
        check(n == 5, "R1 count restarts at 0 (R3 period 5)", n, 5);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule